// File: doc/BRIEF.md
# AXI-Lite Adder Peripheral

This block is a memory-mapped arithmetic slave on a 32-bit AXI-Lite port. A host writes two unsigned operands and then a start command. The block forms the 33-bit unsigned sum of the operands. It raises a ready flag and serves the sum and the carry-out from two read-only registers. The ready flag stays set until the host has read both result registers. It then clears by itself, so a polling host sees each result exactly once.

A five-state transaction controller moves through IDLE, WRITE_WAIT, WRITE, WRITE_RESP and READ. Its transitions are as follows:

- **IDLE to WRITE**: the write address and write data are both accepted in the same cycle.
- **IDLE to WRITE_WAIT**: only one of the two is accepted.
- **IDLE to READ**: a read address is accepted while no write channel is presenting.
- **WRITE_WAIT to WRITE**: the missing write channel arrives.
- **WRITE to WRITE_RESP**: this happens unconditionally after the single commit cycle.
- **WRITE_RESP to IDLE**: the response is taken when bready is high.
- **READ to IDLE**: the data is taken when rready is high.

Only one transaction is in flight at a time. Every response is OKAY.

Top module: `axil_adder_periph`

## Requirements
- R1: After a synchronous active-low reset, the following hold:
  - awready and wready are 1, and bvalid and rvalid are 0.
  - Reads of offsets 0x00, 0x04, 0x08, 0x0C and 0x10 all return 0.
- R2: Offset 0x00 (operand A) and offset 0x04 (operand B) are full 32-bit read/write registers.
- R3: Writing a value with bit 0 set to offset 0x10 loads the unsigned 33-bit result of A + B into the result registers. The sum goes to offset 0x08 and the carry to bit 0 of offset 0x0C, whose bits 31:1 read 0. Both are valid by the cycle in which bvalid for that write rises.
- R4: A read of offset 0x10 returns the ready flag in bit 1, 0 in bit 0 (start is self-clearing), and 0 in bits 31:2. The ready flag is 1 once a start has completed.
- R5: The ready flag clears at the edge that accepts the read address of the later of the sum and carry reads, in either order. Reading only one of them, or reading either one twice, leaves it set.
- R6: A start issued while ready is set does three things: it overwrites sum and carry, it forgets which result registers were already read, and it leaves ready set.
- R7: A read of any other address, including unaligned ones, returns 0xDEADBEEF.
- R8: A write to 0x08, 0x0C or an unmapped address, or a write to 0x10 with bit 0 clear, changes no readable state and is answered OKAY (bresp 2'b00).
- R9: Write address and write data are accepted in either order. In WRITE_WAIT only the ready of the still-missing channel is high.
- R10: In IDLE, arready is low whenever awvalid or wvalid is high, so writes win over reads.
- R11: bvalid stays high until bready is seen. rvalid and rdata stay unchanged until rready is seen. rresp is 2'b00.
- R12: In WRITE, WRITE_RESP and READ, the three ready outputs awready, wready and arready are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awaddr | input | 32 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 32 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
After the edge that completes the second write channel, the controller spends one cycle in WRITE. During that cycle bvalid is 0 and every ready is 0. Register contents and the start result are updated at the next edge, and bvalid rises with them, so the bench reads results only after taking the response.

Read data is registered at the edge that accepts the read address, and rvalid is high in the following cycle. The ready-flag clear also lands on that address edge, so a status read issued after the second result read must already show 0. The bench drives and samples on falling edges and holds bready or rready low for random cycles to check that the response is held.

// File: rtl/adder_periph_pkg.sv
package adder_periph_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WRITE_WAIT = 3'd1,
        ST_WRITE      = 3'd2,
        ST_WRITE_RESP = 3'd3,
        ST_READ       = 3'd4
    } txn_state_e;

    localparam logic [1:0]  RESP_OKAY        = 2'b00;
    localparam logic [31:0] UNMAPPED_PATTERN = 32'hDEAD_BEEF;

    localparam int OFS_OPA  = 'h00;
    localparam int OFS_OPB  = 'h04;
    localparam int OFS_SUM  = 'h08;
    localparam int OFS_CRY  = 'h0C;
    localparam int OFS_CTRL = 'h10;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_READY_BIT = 1;

endpackage

// File: rtl/adder_core.sv
module adder_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum,
    output logic             carry
);
    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] wide;

    always_comb begin
        wide  = {1'b0, op_a} + {1'b0, op_b};
        sum   = wide[WIDTH-1:0];
        carry = wide[EXT_W-1];
    end

endmodule

// File: rtl/adder_axil_ctrl.sv
module adder_axil_ctrl
    import adder_periph_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic              rvalid,
    input  logic              rready,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_capture,
    output logic [ADDR_W-1:0] rd_addr
);
    txn_state_e state_q, state_d;

    logic              aw_held_q, w_held_q;
    logic [ADDR_W-1:0] awaddr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              aw_hs, w_hs, ar_hs, b_hs, r_hs;

    assign aw_hs = awvalid && awready;
    assign w_hs  = wvalid  && wready;
    assign ar_hs = arvalid && arready;
    assign b_hs  = (state_q == ST_WRITE_RESP) && bready;
    assign r_hs  = (state_q == ST_READ) && rready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (aw_hs && w_hs) begin
                    state_d = ST_WRITE;
                end else if (aw_hs || w_hs) begin
                    state_d = ST_WRITE_WAIT;
                end else if (ar_hs) begin
                    state_d = ST_READ;
                end
            end
            ST_WRITE_WAIT: begin
                if (aw_hs || w_hs) begin
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE:      state_d = ST_WRITE_RESP;
            ST_WRITE_RESP: if (b_hs) state_d = ST_IDLE;
            ST_READ:       if (r_hs) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Channel outputs per state
    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        arready = 1'b0;
        bvalid  = 1'b0;
        rvalid  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                awready = 1'b1;
                wready  = 1'b1;
                arready = !(awvalid || wvalid);
            end
            ST_WRITE_WAIT: begin
                awready = !aw_held_q;
                wready  = !w_held_q;
            end
            ST_WRITE_RESP: bvalid = 1'b1;
            ST_READ:       rvalid = 1'b1;
            default: ;
        endcase
    end

    // Hold whichever write half arrived first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_held_q <= 1'b0;
            w_held_q  <= 1'b0;
            awaddr_q  <= '0;
            wdata_q   <= '0;
        end else begin
            if (aw_hs) begin
                awaddr_q  <= awaddr;
                aw_held_q <= 1'b1;
            end
            if (w_hs) begin
                wdata_q  <= wdata;
                w_held_q <= 1'b1;
            end
            if (state_q == ST_WRITE) begin
                aw_held_q <= 1'b0;
                w_held_q  <= 1'b0;
            end
        end
    end

    assign wr_commit  = (state_q == ST_WRITE);
    assign wr_addr    = awaddr_q;
    assign wr_data    = wdata_q;
    assign rd_capture = ar_hs;
    assign rd_addr    = araddr;

    AST_READIES_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_WRITE, ST_WRITE_RESP, ST_READ}) |-> !(awready || wready || arready)); // R12
    AST_WAIT_ONE_MISSING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE_WAIT) |-> $onehot({awready, wready})); // R9
    AST_WRITES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid || wvalid) |-> !arready); // R10
    AST_BVALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid); // R11
    AST_COMMIT_THEN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> bvalid); // R11
    AST_COMMIT_HAS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (aw_held_q && w_held_q)); // R9

endmodule

// File: rtl/adder_regfile.sv
module adder_regfile
    import adder_periph_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_capture,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_OPA  = ADDR_W'(OFS_OPA);
    localparam logic [ADDR_W-1:0] A_OPB  = ADDR_W'(OFS_OPB);
    localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'(OFS_SUM);
    localparam logic [ADDR_W-1:0] A_CRY  = ADDR_W'(OFS_CRY);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    logic [DATA_W-1:0] opa_q, opb_q, sum_q, rdata_q, rd_mux, add_sum;
    logic              carry_q, ready_q, add_carry;
    logic              seen_sum_q, seen_cry_q;
    logic              start_cmd;

    adder_core #(.WIDTH(DATA_W)) u_add (
        .op_a  (opa_q),
        .op_b  (opb_q),
        .sum   (add_sum),
        .carry (add_carry)
    );

    assign start_cmd = wr_commit && (wr_addr == A_CTRL) && wr_data[CTRL_START_BIT];

    always_comb begin
        rd_mux = DATA_W'(UNMAPPED_PATTERN);
        if (rd_addr == A_OPA)  rd_mux = opa_q;
        if (rd_addr == A_OPB)  rd_mux = opb_q;
        if (rd_addr == A_SUM)  rd_mux = sum_q;
        if (rd_addr == A_CRY)  rd_mux = DATA_W'(carry_q);
        if (rd_addr == A_CTRL) rd_mux = DATA_W'({ready_q, 1'b0});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q      <= '0;
            opb_q      <= '0;
            sum_q      <= '0;
            carry_q    <= 1'b0;
            ready_q    <= 1'b0;
            seen_sum_q <= 1'b0;
            seen_cry_q <= 1'b0;
            rdata_q    <= '0;
        end else begin
            if (wr_commit && wr_addr == A_OPA) opa_q <= wr_data;
            if (wr_commit && wr_addr == A_OPB) opb_q <= wr_data;
            if (start_cmd) begin
                sum_q      <= add_sum;
                carry_q    <= add_carry;
                ready_q    <= 1'b1;
                seen_sum_q <= 1'b0;
                seen_cry_q <= 1'b0;
            end
            if (rd_capture) begin
                rdata_q <= rd_mux;
                if (ready_q && rd_addr == A_SUM) begin
                    if (seen_cry_q) begin
                        ready_q    <= 1'b0;
                        seen_cry_q <= 1'b0;
                    end else begin
                        seen_sum_q <= 1'b1;
                    end
                end
                if (ready_q && rd_addr == A_CRY) begin
                    if (seen_sum_q) begin
                        ready_q    <= 1'b0;
                        seen_sum_q <= 1'b0;
                    end else begin
                        seen_cry_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign rdata = rdata_q;

    AST_START_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd |=> ready_q); // R3
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q && !start_cmd) |=> (ready_q || $past(rd_capture))); // R5
    AST_CLEAR_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_capture && rd_addr == A_SUM && !seen_cry_q) |=> ready_q == $past(ready_q)); // R5
    AST_OPS_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> ($stable(opa_q) && $stable(opb_q))); // R8

endmodule

// File: rtl/axil_adder_periph.sv
module axil_adder_periph
    import adder_periph_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready
);
    logic              wr_commit, rd_capture;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data;

    adder_axil_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .awaddr     (s_awaddr),
        .awvalid    (s_awvalid),
        .awready    (s_awready),
        .wdata      (s_wdata),
        .wvalid     (s_wvalid),
        .wready     (s_wready),
        .bvalid     (s_bvalid),
        .bready     (s_bready),
        .araddr     (s_araddr),
        .arvalid    (s_arvalid),
        .arready    (s_arready),
        .rvalid     (s_rvalid),
        .rready     (s_rready),
        .wr_commit  (wr_commit),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_capture (rd_capture),
        .rd_addr    (rd_addr)
    );

    adder_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_commit  (wr_commit),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_capture (rd_capture),
        .rd_addr    (rd_addr),
        .rdata      (s_rdata)
    );

    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata))); // R11
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_bvalid && s_rvalid)); // R11

endmodule

// File: tb/axil_adder_periph_tb_top.sv
module axil_adder_periph_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] awaddr = '0, wdata = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [31:0] m_a = '0, m_b = '0, m_sum = '0;
    logic        m_cry = 1'b0, m_rdy = 1'b0, m_seen_s = 1'b0, m_seen_c = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axil_adder_periph dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [31:0] a);
        case (a)
            32'h00:  return m_a;
            32'h04:  return m_b;
            32'h08:  return m_sum;
            32'h0C:  return {31'b0, m_cry};
            32'h10:  return {30'b0, m_rdy, 1'b0};
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    task automatic model_after_rd(input logic [31:0] a);
        if (m_rdy && a == 32'h08) begin
            if (m_seen_c) begin m_rdy = 1'b0; m_seen_c = 1'b0; end
            else m_seen_s = 1'b1;
        end
        if (m_rdy && a == 32'h0C) begin
            if (m_seen_s) begin m_rdy = 1'b0; m_seen_s = 1'b0; end
            else m_seen_c = 1'b1;
        end
    endtask

    task automatic model_wr(input logic [31:0] a, input logic [31:0] d);
        if (a == 32'h00) m_a = d;
        if (a == 32'h04) m_b = d;
        if (a == 32'h10 && d[0]) begin
            {m_cry, m_sum} = {1'b0, m_a} + {1'b0, m_b};
            m_rdy = 1'b1; m_seen_s = 1'b0; m_seen_c = 1'b0;
        end
    endtask

    // mode 0: AW and W together, 1: AW first, 2: W first
    task automatic axi_wr(input logic [31:0] a, input logic [31:0] d, input int mode, input int bdly);
        logic aw_done, w_done, a_hs, w_hs;
        aw_done = 1'b0; w_done = 1'b0;
        @(negedge clk);
        awaddr = a; wdata = d;
        awvalid = (mode != 2); wvalid = (mode != 1);
        while (!(aw_done && w_done)) begin
            #1;
            a_hs = awvalid && awready;
            w_hs = wvalid && wready;
            @(negedge clk);
            if (a_hs) begin aw_done = 1'b1; awvalid = 1'b0; end
            if (w_hs) begin w_done = 1'b1; wvalid = 1'b0; end
            if (aw_done && !w_done) begin
                wvalid = 1'b1; #1;
                chk("R9 wait awready", {31'b0, awready}, 32'd0);
                chk("R9 wait wready", {31'b0, wready}, 32'd1);
            end else if (w_done && !aw_done) begin
                awvalid = 1'b1; #1;
                chk("R9 wait wready", {31'b0, wready}, 32'd0);
                chk("R9 wait awready", {31'b0, awready}, 32'd1);
            end
        end
        #1;
        chk("R12 readies in WRITE", {29'b0, awready, wready, arready}, 32'd0);
        chk("R11 no early bvalid", {31'b0, bvalid}, 32'd0);
        @(negedge clk);
        chk("R11 bvalid", {31'b0, bvalid}, 32'd1);
        chk("R8 bresp OKAY", {30'b0, bresp}, 32'd0);
        chk("R12 readies in WRITE_RESP", {29'b0, awready, wready, arready}, 32'd0);
        for (int i = 0; i < bdly; i++) begin
            @(negedge clk);
            chk("R11 bvalid held", {31'b0, bvalid}, 32'd1);
        end
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0; #1;
        chk("R11 bvalid drop", {31'b0, bvalid}, 32'd0);
        model_wr(a, d);
    endtask

    task automatic axi_rd(input logic [31:0] a, input int rdly, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1'b1; #1;
        while (!arready) begin @(negedge clk); #1; end
        @(negedge clk);
        arvalid = 1'b0; #1;
        chk("R11 rvalid", {31'b0, rvalid}, 32'd1);
        chk("R11 rresp OKAY", {30'b0, rresp}, 32'd0);
        chk("R12 readies in READ", {29'b0, awready, wready, arready}, 32'd0);
        d = rdata;
        for (int i = 0; i < rdly; i++) begin
            @(negedge clk);
            chk("R11 rdata held", rdata, d);
            chk("R11 rvalid held", {31'b0, rvalid}, 32'd1);
        end
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0; #1;
        chk("R11 rvalid drop", {31'b0, rvalid}, 32'd0);
    endtask

    task automatic rd_chk(input logic [31:0] a, input string req, input int rdly);
        logic [31:0] got, exp;
        exp = model_rd(a);
        axi_rd(a, rdly, got);
        chk(req, got, exp);
        model_after_rd(a);
    endtask

    function automatic logic [31:0] rand_operand();
        int sel;
        sel = $urandom_range(0, 7);
        if (sel == 0) return 32'hFFFF_FFFF;
        if (sel == 1) return 32'h0;
        return $urandom;
    endfunction

    function automatic logic [31:0] rand_unmapped();
        logic [31:0] a;
        a = $urandom;
        if (a < 32'h14 && a[1:0] == 2'b00) a = a | 32'h100;
        return a;
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] addrs [5];
        addrs[0] = 32'h00; addrs[1] = 32'h04; addrs[2] = 32'h08;
        addrs[3] = 32'h0C; addrs[4] = 32'h10;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        #1;
        chk("R1 awready", {31'b0, awready}, 32'd1);
        chk("R1 wready", {31'b0, wready}, 32'd1);
        chk("R1 bvalid", {31'b0, bvalid}, 32'd0);
        chk("R1 rvalid", {31'b0, rvalid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) rd_chk(addrs[i], "R1 reset value", 0);

        // Operands round-trip
        axi_wr(32'h00, 32'hFFFF_FFFF, 0, 0);
        axi_wr(32'h04, 32'h0000_0001, 1, 2);
        rd_chk(32'h00, "R2 operand A", 0);
        rd_chk(32'h04, "R2 operand B", 1);

        // Start with carry; result must be there when the response is taken
        axi_wr(32'h10, 32'h0000_0001, 2, 1);
        rd_chk(32'h10, "R4 ready set, start reads 0", 0);
        rd_chk(32'h08, "R3 sum with carry", 0);
        rd_chk(32'h08, "R5 second sum read", 0);
        rd_chk(32'h10, "R5 ready kept after one register", 0);
        rd_chk(32'h0C, "R3 carry bit", 2);
        rd_chk(32'h10, "R5 ready cleared after both", 0);

        // Reverse order, restart in the middle
        axi_wr(32'h04, 32'h1234_5678, 0, 0);
        axi_wr(32'h10, 32'hFFFF_FFFF, 0, 0);
        rd_chk(32'h0C, "R5 carry first", 0);
        axi_wr(32'h00, 32'h0000_0010, 1, 0);
        axi_wr(32'h10, 32'h0000_0001, 0, 0);
        rd_chk(32'h08, "R6 sum after restart", 0);
        rd_chk(32'h10, "R6 ready still set", 0);
        rd_chk(32'h0C, "R6 carry after restart", 0);
        rd_chk(32'h10, "R5 cleared after both", 0);

        // Ignored writes
        axi_wr(32'h08, 32'hAAAA_AAAA, 0, 0);
        axi_wr(32'h0C, 32'h0000_0001, 2, 0);
        axi_wr(32'h10, 32'h0000_0002, 0, 0);
        axi_wr(32'h0000_0200, 32'h5555_5555, 1, 0);
        for (int i = 0; i < 5; i++) rd_chk(addrs[i], "R8 unchanged after ignored writes", 0);

        // Unmapped reads
        rd_chk(32'h14, "R7 unmapped", 0);
        rd_chk(32'h02, "R7 unaligned", 0);
        rd_chk(32'hFFFF_FFFC, "R7 high address", 0);

        // Write priority over read
        @(negedge clk);
        arvalid = 1'b1; araddr = 32'h00; awvalid = 1'b1; awaddr = 32'h00;
        #1;
        chk("R10 arready low while write pending", {31'b0, arready}, 32'd0);
        awvalid = 1'b0;
        #1;
        chk("R10 arready back in IDLE", {31'b0, arready}, 32'd1);
        arvalid = 1'b0;

        // Random traffic
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0: axi_wr(32'h00, rand_operand(), $urandom_range(0, 2), $urandom_range(0, 2));
                1: axi_wr(32'h04, rand_operand(), $urandom_range(0, 2), $urandom_range(0, 2));
                2: axi_wr(32'h10, {$urandom} | 32'h1, $urandom_range(0, 2), $urandom_range(0, 2));
                8: rd_chk(rand_unmapped(), "R7 random unmapped", $urandom_range(0, 2));
                9: axi_wr(($urandom_range(0, 1) == 0) ? addrs[$urandom_range(2, 3)] : rand_unmapped(),
                          $urandom, $urandom_range(0, 2), 0);
                default: rd_chk(addrs[$urandom_range(0, 4)], "R3 R5 random read", $urandom_range(0, 2));
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule